// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This peripheral keeps time in whole seconds for a small system. A prescaler divides the bus clock so that an absolute seconds count advances once every `CLK_HZ` cycles. A second, relative count shows the seconds elapsed since software last restarted it. Software reaches the block through a 32-bit register bus with an address and a select/enable handshake. The bus decodes a 4 KiB window and finishes every access without wait states.

Software arms an alarm by writing a seconds value into the match register. When the absolute count steps onto that value, an interrupt flag is set, the level interrupt output goes high and a one-cycle event pulse is emitted. Software can also drive the flag from the bus. Writing zero to the interrupt register clears the flag. Writing any non-zero value sets the flag and emits the same one-cycle pulse. Two constant identification words near the top of the window let software recognise the block.

Top module: `rtc_sec_top`

## Requirements
- R1: Only word-sized accesses take effect. A word access has `acc_size` = 2'b10. A write of any other size changes nothing and gives no pulse, and a read of any other size returns zero.
- R2: Offset 0x000 reads the absolute seconds count. That count is 0 after reset and equals floor(k / CLK_HZ) after k rising clock edges with reset released. Writes to 0x000 are ignored.
- R3: Offset 0x004 holds the match value. It resets to zero and reads back exactly the last word written to it.
- R4: A word write of zero to offset 0x008 clears the interrupt flag. A word write of a non-zero value sets the flag and drives `alarm_pulse` high for exactly the one cycle after the write edge.
- R5: A read of offset 0x008 returns the flag in bit 0, with bits 31:1 always zero. The flag is clear after reset, and `irq` equals the flag.
- R6: Any word write to offset 0x010 records the absolute count of that cycle as the base. A read of 0x010 returns the absolute count minus the base, modulo 2^32. The base is 0 after reset.
- R7: Offset 0x00C always reads zero, and writes to it change no register.
- R8: Offset 0xFE0 reads 0x00041030 and offset 0xFD8 reads 0x000FFFFF.
- R9: When the absolute count advances to a value equal to the match value, the flag is set and `alarm_pulse` is high in the cycle after that edge. The pulse is high alongside the first cycle in which the new count is visible. If this happens in the same cycle as a clear, the set wins.
- R10: Any other offset, including an offset that is not word-aligned, reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timekeeping clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Peripheral select |
| bus_en | input | 1 | Access phase; a transfer happens when select and enable are both high |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset inside the 4 KiB window |
| acc_size | input | 2 | Access size: 00 byte, 01 half-word, 10 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the access phase |
| irq | output | 1 | Level interrupt, equal to the flag |
| alarm_pulse | output | 1 | One-cycle event on an alarm hit or a software set |

## Verification
A prescaler that slips by one cycle shows at the ports within one second period. The data register then reads one second off the count of clock edges, and an alarm edge arrives a cycle early or late against `irq`. A wrong base register shows on the very next read of the relative counter. A flag that fails to hold, or that holds when it should not, shows at `irq` on the cycle after the write or hit that should have changed it. The same fault shows on the status bit at the next read. Decode faults show at once, because each offset is read back after the writes to its neighbours.

// File: rtl/rtc_sec_pkg.sv
// Package: shared constants for the seconds RTC.
// Holds the register offsets, the access-size encoding and the constant
// identification words. Offsets are byte offsets within a 4 KiB window.
package rtc_sec_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 12;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    localparam logic [ADDR_W-1:0] OFF_NOW     = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_ALARM   = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_IRQ     = 12'h008;
    localparam logic [ADDR_W-1:0] OFF_LOAD    = 12'h00C;
    localparam logic [ADDR_W-1:0] OFF_ELAPSED = 12'h010;
    localparam logic [ADDR_W-1:0] OFF_IDMASK  = 12'hFD8;
    localparam logic [ADDR_W-1:0] OFF_IDENT   = 12'hFE0;

    localparam logic [DATA_W-1:0] IDENT_WORD  = 32'h0004_1030;
    localparam logic [DATA_W-1:0] IDMASK_WORD = 32'h000F_FFFF;
endpackage

// File: rtl/rtc_prescaler.sv
// Module: rtc_prescaler
// Produces a one-cycle tick once every CLK_HZ clock cycles.
// The first tick comes CLK_HZ cycles after reset is released.
// Assumes CLK_HZ >= 1; with CLK_HZ of 1 the tick is high in every cycle.
module rtc_prescaler #(
    parameter int unsigned CLK_HZ = 32768
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (CLK_HZ <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_div
            localparam int unsigned CNT_W = $clog2(CLK_HZ);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_HZ - 1);

            logic [CNT_W-1:0] cnt_q;

            // Purpose: count cycles within one second, wrapping at LAST.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end

            assign tick = (cnt_q == LAST);

            AST_PRESC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
                (cnt_q == LAST) |=> (cnt_q == '0)); // R2
        end
    endgenerate
endmodule

// File: rtl/rtc_sec_counter.sv
// Module: rtc_sec_counter
// Holds the absolute seconds count. It advances by one on each prescaler
// tick and wraps modulo 2^DATA_W. It flags a hit when the value it is
// about to take equals the match value.
// Assumes tick is a single-cycle strobe.
module rtc_sec_counter
    import rtc_sec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [DATA_W-1:0] match_val,
    output logic [DATA_W-1:0] secs,
    output logic              hit
);
    logic [DATA_W-1:0] secs_next;

    assign secs_next = secs + 1'b1;

    // Purpose: advance the absolute seconds on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            secs <= '0;
        end else if (tick) begin
            secs <= secs_next;
        end
    end

    // Purpose: detect the step onto the match value.
    assign hit = tick && (secs_next == match_val);

    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (secs == $past(secs))); // R2
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (secs == $past(secs) + 32'd1)); // R2
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Module: rtc_irq_ctrl
// Holds the interrupt flag and builds the one-cycle event pulse.
// An alarm hit or a software set raises the flag; a software clear lowers it.
// A set wins over a clear in the same cycle.
// Assumes the request inputs are single-cycle strobes.
module rtc_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic sw_set,
    input  logic sw_clr,
    output logic flag,
    output logic pulse
);
    logic raise;

    assign raise = hit || sw_set;

    // Purpose: update the interrupt flag, with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (raise) begin
            flag <= 1'b1;
        end else if (sw_clr) begin
            flag <= 1'b0;
        end
    end

    // Purpose: register the event pulse for the cycle after a raise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= raise;
        end
    end

    AST_PULSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> flag); // R4
    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !hit && !sw_set) |=> !flag); // R4
    AST_HIT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (flag && pulse)); // R9
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !sw_set && !sw_clr) |=> (flag == $past(flag))); // R5
endmodule

// File: rtl/rtc_bus_regs.sv
// Module: rtc_bus_regs
// Decodes the bus, holds the match and base registers, and builds the
// read data. Only word-sized accesses act. A transfer happens in a cycle
// where both select and enable are high; read data is combinational in
// that cycle.
module rtc_bus_regs
    import rtc_sec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_en,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        acc_size,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] secs,
    input  logic              flag,
    output logic [DATA_W-1:0] match_val,
    output logic              sw_set,
    output logic              sw_clr,
    output logic [DATA_W-1:0] bus_rdata
);
    logic              access;
    logic              is_word;
    logic              wr_en;
    logic              rd_en;
    logic              match_we;
    logic              base_we;
    logic [DATA_W-1:0] match_q;
    logic [DATA_W-1:0] base_q;
    logic [DATA_W-1:0] rd_mux;

    assign access   = bus_sel && bus_en;
    assign is_word  = (acc_size == SZ_WORD);
    assign wr_en    = access && bus_write && is_word;
    assign rd_en    = access && !bus_write && is_word;
    assign match_we = wr_en && (bus_addr == OFF_ALARM);
    assign base_we  = wr_en && (bus_addr == OFF_ELAPSED);
    assign sw_set   = wr_en && (bus_addr == OFF_IRQ) && (bus_wdata != '0);
    assign sw_clr   = wr_en && (bus_addr == OFF_IRQ) && (bus_wdata == '0);

    // Purpose: store the alarm match value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
        end else if (match_we) begin
            match_q <= bus_wdata;
        end
    end

    // Purpose: record the absolute seconds as the base of the relative count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (base_we) begin
            base_q <= secs;
        end
    end

    assign match_val = match_q;

    // Purpose: select the read word by offset; unmapped offsets give zero.
    always_comb begin
        case (bus_addr)
            OFF_NOW:     rd_mux = secs;
            OFF_ALARM:   rd_mux = match_q;
            OFF_IRQ:     rd_mux = {{(DATA_W-1){1'b0}}, flag};
            OFF_LOAD:    rd_mux = '0;
            OFF_ELAPSED: rd_mux = secs - base_q;
            OFF_IDMASK:  rd_mux = IDMASK_WORD;
            OFF_IDENT:   rd_mux = IDENT_WORD;
            default:     rd_mux = '0;
        endcase
    end

    // Purpose: drive read data only for word reads.
    assign bus_rdata = rd_en ? rd_mux : '0;

    AST_NONWORD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !is_word) |-> (bus_rdata == '0)); // R1
    AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !match_we |=> $stable(match_q)); // R3
    AST_STATUS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && bus_addr == OFF_IRQ) |-> (bus_rdata[DATA_W-1:1] == '0)); // R5
    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !base_we |=> $stable(base_q)); // R6
    AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_set && sw_clr)); // R4
endmodule

// File: rtl/rtc_sec_top.sv
// Module: rtc_sec_top
// Top of the seconds RTC. It wires the prescaler, the seconds counter,
// the interrupt control and the bus register block together.
// Assumes a single clock, with the bus and the timekeeping in the same domain.
module rtc_sec_top #(
    parameter int unsigned CLK_HZ = 32768
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_en,
    input  logic        bus_write,
    input  logic [11:0] bus_addr,
    input  logic [1:0]  acc_size,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        alarm_pulse
);
    import rtc_sec_pkg::*;

    logic              tick;
    logic              hit;
    logic              sw_set;
    logic              sw_clr;
    logic              flag;
    logic [DATA_W-1:0] secs;
    logic [DATA_W-1:0] match_val;

    rtc_prescaler #(.CLK_HZ(CLK_HZ)) presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rtc_sec_counter cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .match_val (match_val),
        .secs      (secs),
        .hit       (hit)
    );

    rtc_irq_ctrl irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .flag   (flag),
        .pulse  (alarm_pulse)
    );

    rtc_bus_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_en    (bus_en),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .acc_size  (acc_size),
        .bus_wdata (bus_wdata),
        .secs      (secs),
        .flag      (flag),
        .match_val (match_val),
        .sw_set    (sw_set),
        .sw_clr    (sw_clr),
        .bus_rdata (bus_rdata)
    );

    assign irq = flag;

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_pulse |-> irq); // R5
endmodule

// File: tb/rtc_sec_top_tb_top.sv
// Directed bench for rtc_sec_top. It models the absolute seconds as
// floor(edges / N), where edges counts the rising edges with reset released.
module rtc_sec_top_tb_top;
    localparam int unsigned N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [1:0]  acc_size = 2'b10;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        alarm_pulse;

    int unsigned edges = 0;
    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned wr_edges = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) if (rst_n) edges <= edges + 1;

    rtc_sec_top #(.CLK_HZ(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
        .bus_write(bus_write), .bus_addr(bus_addr), .acc_size(acc_size),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .alarm_pulse(alarm_pulse)
    );

    function automatic logic [31:0] now_s();
        return 32'(edges / N);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Write: setup phase, access phase, then idle; returns at the idle negedge.
    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz);
        @(negedge clk);
        bus_sel = 1'b1; bus_en = 1'b0; bus_write = 1'b1;
        bus_addr = a; bus_wdata = d; acc_size = sz;
        @(negedge clk);
        bus_en = 1'b1;
        wr_edges = edges;
        @(negedge clk);
        bus_sel = 1'b0; bus_en = 1'b0; bus_write = 1'b0; acc_size = 2'b10;
        #0.5;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [1:0] sz,
                          output logic [31:0] d, output logic [31:0] secs_at);
        @(negedge clk);
        bus_sel = 1'b1; bus_en = 1'b0; bus_write = 1'b0;
        bus_addr = a; acc_size = sz;
        @(negedge clk);
        bus_en = 1'b1;
        #0.5;
        d = bus_rdata;
        secs_at = now_s();
        @(negedge clk);
        bus_sel = 1'b0; bus_en = 1'b0; acc_size = 2'b10;
    endtask

    task automatic t_reset();
        logic [31:0] d, s;
        chk("R5 irq after reset", {31'd0, irq}, 32'd0);
        bus_rd(12'h000, 2'b10, d, s); chk("R2 seconds after reset", d, s);
        bus_rd(12'h004, 2'b10, d, s); chk("R3 match reset", d, 32'd0);
        bus_rd(12'h008, 2'b10, d, s); chk("R5 status reset", d, 32'd0);
        bus_rd(12'h010, 2'b10, d, s); chk("R6 elapsed from reset base", d, s);
    endtask

    task automatic t_data_ro();
        logic [31:0] d, s;
        repeat (3 * N) @(negedge clk);
        bus_wr(12'h000, 32'hDEAD_0000, 2'b10);
        bus_rd(12'h000, 2'b10, d, s); chk("R2 seconds ignore write", d, s);
        chk("R2 seconds advanced", {31'd0, (s >= 3)}, 32'd1);
    endtask

    task automatic t_match_rw();
        logic [31:0] d, s;
        bus_wr(12'h004, 32'hA5C3_0F01, 2'b10);
        bus_rd(12'h004, 2'b10, d, s); chk("R3 match readback", d, 32'hA5C3_0F01);
        bus_wr(12'h004, 32'h7FFF_FFF0, 2'b10);
        bus_rd(12'h004, 2'b10, d, s); chk("R3 match rewrite", d, 32'h7FFF_FFF0);
    endtask

    task automatic t_word_only();
        logic [31:0] d, s;
        bus_wr(12'h004, 32'h1111_2222, 2'b00);
        bus_rd(12'h004, 2'b10, d, s); chk("R1 byte write ignored", d, 32'h7FFF_FFF0);
        bus_wr(12'h004, 32'h3333_4444, 2'b01);
        bus_rd(12'h004, 2'b10, d, s); chk("R1 half write ignored", d, 32'h7FFF_FFF0);
        bus_wr(12'h008, 32'h1, 2'b00);
        chk("R1 byte set no pulse", {31'd0, alarm_pulse}, 32'd0);
        chk("R1 byte set no irq", {31'd0, irq}, 32'd0);
        bus_rd(12'h004, 2'b00, d, s); chk("R1 byte read zero", d, 32'd0);
        bus_rd(12'hFE0, 2'b01, d, s); chk("R1 half read zero", d, 32'd0);
    endtask

    task automatic t_irq_sw();
        logic [31:0] d, s;
        bus_wr(12'h008, 32'h0000_0100, 2'b10);
        chk("R4 set pulse high", {31'd0, alarm_pulse}, 32'd1);
        chk("R5 irq follows set", {31'd0, irq}, 32'd1);
        @(negedge clk); #0.5;
        chk("R4 pulse one cycle", {31'd0, alarm_pulse}, 32'd0);
        bus_rd(12'h008, 2'b10, d, s); chk("R5 status set", d, 32'd1);
        bus_wr(12'h008, 32'd0, 2'b10);
        chk("R4 clear irq", {31'd0, irq}, 32'd0);
        chk("R4 clear no pulse", {31'd0, alarm_pulse}, 32'd0);
        bus_rd(12'h008, 2'b10, d, s); chk("R5 status clear", d, 32'd0);
    endtask

    task automatic t_elapsed();
        logic [31:0] d, s, base;
        bus_wr(12'h010, 32'h0BAD_F00D, 2'b10);
        base = 32'(wr_edges / N);
        repeat (2 * N + 3) @(negedge clk);
        bus_rd(12'h010, 2'b10, d, s); chk("R6 elapsed after restart", d, s - base);
        bus_rd(12'h000, 2'b10, d, s); chk("R6 absolute unaffected", d, s);
    endtask

    task automatic t_load();
        logic [31:0] d, s;
        bus_wr(12'h00C, 32'h1234_5678, 2'b10);
        bus_rd(12'h00C, 2'b10, d, s); chk("R7 load reads zero", d, 32'd0);
        bus_rd(12'h000, 2'b10, d, s); chk("R7 seconds unchanged", d, s);
        bus_rd(12'h004, 2'b10, d, s); chk("R7 match unchanged", d, 32'h7FFF_FFF0);
    endtask

    task automatic t_ident();
        logic [31:0] d, s;
        bus_rd(12'hFE0, 2'b10, d, s); chk("R8 ident word", d, 32'h0004_1030);
        bus_rd(12'hFD8, 2'b10, d, s); chk("R8 mask word", d, 32'h000F_FFFF);
    endtask

    task automatic t_unmapped();
        logic [31:0] d, s;
        bus_wr(12'h014, 32'hFFFF_FFFF, 2'b10);
        bus_wr(12'h005, 32'h0000_0001, 2'b10);
        bus_wr(12'h009, 32'h0000_0001, 2'b10);
        chk("R10 no irq from unmapped", {31'd0, irq}, 32'd0);
        bus_rd(12'h014, 2'b10, d, s); chk("R10 unmapped reads zero", d, 32'd0);
        bus_rd(12'h006, 2'b10, d, s); chk("R10 unaligned reads zero", d, 32'd0);
        bus_rd(12'h004, 2'b10, d, s); chk("R10 match untouched", d, 32'h7FFF_FFF0);
    endtask

    task automatic t_alarm();
        logic [31:0] m;
        bit early = 1'b0;
        m = now_s() + 32'd3;
        bus_wr(12'h004, m, 2'b10);
        while (now_s() != m) begin
            if (irq || alarm_pulse) early = 1'b1;
            @(negedge clk); #0.5;
        end
        chk("R9 no early alarm", {31'd0, early}, 32'd0);
        chk("R9 irq at match", {31'd0, irq}, 32'd1);
        chk("R9 pulse at match", {31'd0, alarm_pulse}, 32'd1);
        @(negedge clk); #0.5;
        chk("R9 pulse single", {31'd0, alarm_pulse}, 32'd0);
        chk("R9 irq held", {31'd0, irq}, 32'd1);
        bus_wr(12'h008, 32'd0, 2'b10);
        chk("R9 cleared after alarm", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #0.5;
        t_reset();
        t_data_ro();
        t_match_rw();
        t_word_only();
        t_irq_sw();
        t_elapsed();
        t_load();
        t_ident();
        t_unmapped();
        t_alarm();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule